// File: doc/BRIEF.md
# HDLC Receive Frame Acceptance Filter

This block sits behind a bit-level HDLC receiver that has already found the flags, removed the stuffed bits and checked the CRC. The receiver hands over one byte at a time with a valid strobe. Alongside each byte it can raise an overrun indication, an abort indication, an end-of-frame strobe and a CRC-error flag. The filter writes the bytes of the frame in progress into an external frame buffer, starting at address zero. When the frame ends, it decides whether the frame is kept.

A frame is kept only if all of these hold: it reached a minimum length, the CRC was good, and the receive path was clean when the frame ended. A kept frame produces a one-clock acceptance pulse. The pulse carries the payload length, which is the stored byte count with the two trailing CRC bytes removed. Rejected frames are dropped without a pulse.

Overruns and buffer overflow both cause bytes to be discarded until the path recovers. Three saturating statistics counters record kept frames, overruns and CRC errors. A CRC error is only counted when the frame was long enough not to be line noise.

Top module: `hdlc_rx_filter`

## Requirements
- R1: After reset the three counters read 0, `frameOk` is 0, and with no input activity `bufWrEn` is 0.
- R2: While the receive path is active, each valid byte is presented on the write port in its own cycle. `bufWrEn` is 1, `bufWrData` equals the byte, and `bufWrAddr` counts up from 0 for each byte of the frame.
- R3: A valid byte flagged as overrun is not written. It clears the byte count and increments the overrun counter. The next valid byte is also dropped, which returns the path to active. The byte after that is written at address 0.
- R4: When `BUF_SIZE` bytes are already stored, the next valid byte is not written. It clears the byte count and marks the frame too big. The byte after it is dropped and returns the path to active. Storing then resumes at address 0.
- R5: An end of frame with a count of at least `MIN_LEN`, no CRC error and an active path is a kept frame. In the cycle after the end-of-frame cycle, `frameOk` is 1 for exactly one cycle, and `frameLen` is the count minus 2. The kept-frame counter increments.
- R6: An end of frame with a count from 1 to `MIN_LEN`-1 gives no pulse and changes no counter, whether or not the CRC-error flag is set.
- R7: An end of frame with a count of at least `MIN_LEN` and the CRC-error flag set gives no pulse and increments the CRC-error counter.
- R8: After any end of frame, the next byte is written at address 0 and the path is active.
- R9: An abort while the path is active clears the count, and a byte arriving in the same cycle is not written. The next byte goes to address 0. An abort while bytes are being dropped has no effect: the next byte is still dropped.
- R10: A byte arriving in the same cycle as the end-of-frame strobe is stored and counts toward the frame length.
- R11: Each counter saturates at 65535 instead of wrapping.
- R12: An end of frame with a count of 0 gives no pulse and changes no counter. This includes an overrun byte that arrives together with the end-of-frame strobe, which still increments the overrun counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Received byte present |
| inByte | input | 8 | Received byte |
| inOverrun | input | 1 | Receiver overrun on this byte |
| inAbort | input | 1 | Abort sequence seen |
| inEof | input | 1 | End of frame strobe |
| inCrcErr | input | 1 | CRC check failed, qualified by inEof |
| bufWrEn | output | 1 | Frame buffer write enable |
| bufWrAddr | output | $clog2(BUF_SIZE) | Frame buffer write address |
| bufWrData | output | 8 | Frame buffer write data |
| frameOk | output | 1 | One-cycle kept-frame pulse |
| frameLen | output | $clog2(BUF_SIZE+1) | Payload length without CRC bytes, valid with frameOk |
| cntFrames | output | 16 | Kept frames, saturating |
| cntOverrun | output | 16 | Overruns, saturating |
| cntCrcErr | output | 16 | CRC errors on full-length frames, saturating |

## Verification
Two functions can act in the same cycle. The first pair is the storing of a byte and the end-of-frame decision. The bench drives the final byte together with the strobe and expects the length to include that byte (R10). The second pair is an overrun and an end of frame arriving together. The bench provokes this after a full-length frame and judges it by three results: no acceptance pulse, an unchanged kept-frame counter, and an incremented overrun counter.

// File: rtl/hdlc_rx_filter_pkg.sv
package hdlc_rx_filter_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_ERROR  = 2'd1,
    ST_BIG    = 2'd2
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic storeByte;
    logic clearCount;
    logic acceptFrame;
    logic bumpFrames;
    logic bumpOverrun;
    logic bumpCrc;
  } filtCtl_t;

  localparam int STAT_NUM  = 3;
  localparam int IDX_FRAME = 0;
  localparam int IDX_OVR   = 1;
  localparam int IDX_CRC   = 2;

endpackage

// File: rtl/hdlc_rx_filter_ctrl.sv
module hdlc_rx_filter_ctrl
  import hdlc_rx_filter_pkg::*;
#(
  parameter int BUF_SIZE = 1024,
  parameter int MIN_LEN  = 10,
  localparam int CNT_W = $clog2(BUF_SIZE + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inOverrun,
  input  logic             inAbort,
  input  logic             inEof,
  input  logic             inCrcErr,
  input  logic [CNT_W-1:0] byteCount,
  output filtCtl_t         ctl
);

  localparam logic [CNT_W-1:0] BUF_LIM = CNT_W'(BUF_SIZE);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_LEN);

  rxState_t rxState, stNext;
  logic [CNT_W-1:0] effCount;

  always_comb begin
    ctl      = '0;
    stNext   = rxState;
    effCount = byteCount;
    if (inAbort && rxState == ST_ACTIVE) begin
      ctl.clearCount = 1'b1;
      effCount       = '0;
    end else if (inValid) begin
      if (inOverrun) begin
        ctl.clearCount  = 1'b1;
        ctl.bumpOverrun = 1'b1;
        effCount        = '0;
        stNext          = ST_ERROR;
      end else if (rxState != ST_ACTIVE) begin
        stNext = ST_ACTIVE;           // drain one byte
      end else if (byteCount >= BUF_LIM) begin
        ctl.clearCount = 1'b1;
        effCount       = '0;
        stNext         = ST_BIG;
      end else begin
        ctl.storeByte = 1'b1;
        effCount      = byteCount + 1'b1;
      end
    end
    if (inEof) begin
      if (effCount != '0) begin
        if (inCrcErr || stNext != ST_ACTIVE || effCount < MIN_CNT) begin
          ctl.bumpCrc = inCrcErr && (effCount >= MIN_CNT);
        end else begin
          ctl.acceptFrame = 1'b1;
          ctl.bumpFrames  = 1'b1;
        end
      end
      ctl.clearCount = 1'b1;
      stNext         = ST_ACTIVE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rxState <= ST_ACTIVE;
    else       rxState <= stNext;
  end

  AST_EOF_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    inEof |=> rxState == ST_ACTIVE); // R8
  AST_DROP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (rxState != ST_ACTIVE) |-> !ctl.storeByte); // R3
  AST_ACCEPT_NO_CRC: assert property (@(posedge clk) disable iff (!rstN)
    ctl.acceptFrame |-> !inCrcErr); // R7
  AST_ABORT_NO_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (inAbort && rxState == ST_ACTIVE) |-> !ctl.storeByte); // R9

endmodule

// File: rtl/hdlc_rx_filter_dp.sv
module hdlc_rx_filter_dp
  import hdlc_rx_filter_pkg::*;
#(
  parameter int BUF_SIZE  = 1024,
  parameter int MIN_LEN   = 10,
  parameter int CRC_BYTES = 2,
  parameter int STAT_W    = 16,
  localparam int CNT_W  = $clog2(BUF_SIZE + 1),
  localparam int ADDR_W = $clog2(BUF_SIZE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  filtCtl_t          ctl,
  input  logic [7:0]        inByte,
  output logic [CNT_W-1:0]  byteCount,
  output logic              bufWrEn,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic [7:0]        bufWrData,
  output logic              frameOk,
  output logic [CNT_W-1:0]  frameLen,
  output logic [STAT_W-1:0] statCnt [STAT_NUM]
);

  localparam logic [CNT_W-1:0] CRC_CNT = CNT_W'(CRC_BYTES);
  localparam logic [CNT_W-1:0] BUF_LIM = CNT_W'(BUF_SIZE);

  logic [CNT_W-1:0] lenRaw;
  logic [STAT_NUM-1:0] bump;

  assign bufWrEn   = ctl.storeByte;
  assign bufWrAddr = byteCount[ADDR_W-1:0];
  assign bufWrData = inByte;
  assign lenRaw    = ctl.storeByte ? byteCount + 1'b1 : byteCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCount <= '0;
      frameOk   <= 1'b0;
      frameLen  <= '0;
    end else begin
      if (ctl.clearCount)     byteCount <= '0;
      else if (ctl.storeByte) byteCount <= byteCount + 1'b1;
      frameOk <= ctl.acceptFrame;
      if (ctl.acceptFrame) frameLen <= lenRaw - CRC_CNT;
    end
  end

  assign bump[IDX_FRAME] = ctl.bumpFrames;
  assign bump[IDX_OVR]   = ctl.bumpOverrun;
  assign bump[IDX_CRC]   = ctl.bumpCrc;

  for (genvar k = 0; k < STAT_NUM; k++) begin : g_stat
    always_ff @(posedge clk) begin
      if (!rstN) statCnt[k] <= '0;
      else if (bump[k] && statCnt[k] != '1) statCnt[k] <= statCnt[k] + 1'b1;
    end
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      statCnt[k] == '1 |=> statCnt[k] == '1); // R11
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameOk |=> !frameOk); // R5
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    byteCount <= BUF_LIM); // R4
  AST_LEN_MIN: assert property (@(posedge clk) disable iff (!rstN)
    frameOk |-> frameLen >= CNT_W'(MIN_LEN - CRC_BYTES)); // R6

endmodule

// File: rtl/hdlc_rx_filter.sv
module hdlc_rx_filter
  import hdlc_rx_filter_pkg::*;
#(
  parameter int BUF_SIZE = 1024,
  parameter int MIN_LEN  = 10,
  parameter int STAT_W   = 16,
  localparam int CNT_W  = $clog2(BUF_SIZE + 1),
  localparam int ADDR_W = $clog2(BUF_SIZE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  input  logic              inOverrun,
  input  logic              inAbort,
  input  logic              inEof,
  input  logic              inCrcErr,
  output logic              bufWrEn,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic [7:0]        bufWrData,
  output logic              frameOk,
  output logic [CNT_W-1:0]  frameLen,
  output logic [STAT_W-1:0] cntFrames,
  output logic [STAT_W-1:0] cntOverrun,
  output logic [STAT_W-1:0] cntCrcErr
);

  filtCtl_t ctl;
  logic [CNT_W-1:0] byteCount;
  logic [STAT_W-1:0] statCnt [STAT_NUM];

  hdlc_rx_filter_ctrl #(.BUF_SIZE(BUF_SIZE), .MIN_LEN(MIN_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOverrun(inOverrun),
    .inAbort(inAbort), .inEof(inEof), .inCrcErr(inCrcErr),
    .byteCount(byteCount), .ctl(ctl)
  );

  hdlc_rx_filter_dp #(.BUF_SIZE(BUF_SIZE), .MIN_LEN(MIN_LEN), .CRC_BYTES(2),
                      .STAT_W(STAT_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inByte(inByte),
    .byteCount(byteCount), .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr),
    .bufWrData(bufWrData), .frameOk(frameOk), .frameLen(frameLen),
    .statCnt(statCnt)
  );

  assign cntFrames  = statCnt[IDX_FRAME];
  assign cntOverrun = statCnt[IDX_OVR];
  assign cntCrcErr  = statCnt[IDX_CRC];

endmodule

// File: tb/hdlc_rx_filter_tb_top.sv
module hdlc_rx_filter_tb_top;

  localparam int BSZ = 32;
  localparam int MINL = 10;
  localparam int CW = $clog2(BSZ + 1);
  localparam int AW = $clog2(BSZ);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 0, inOverrun = 0, inAbort = 0, inEof = 0, inCrcErr = 0;
  logic [7:0] inByte = '0;
  logic bufWrEn, frameOk;
  logic [AW-1:0] bufWrAddr;
  logic [7:0] bufWrData;
  logic [CW-1:0] frameLen;
  logic [15:0] cntFrames, cntOverrun, cntCrcErr;

  int total = 0, bad = 0;
  int expFrames = 0, expOvr = 0, expCrc = 0;
  logic smpWrEn;
  logic [AW-1:0] smpAddr;
  logic [7:0] smpData;

  always #4 clk = ~clk;

  hdlc_rx_filter #(.BUF_SIZE(BSZ), .MIN_LEN(MINL)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .inOverrun(inOverrun), .inAbort(inAbort), .inEof(inEof), .inCrcErr(inCrcErr),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .frameOk(frameOk), .frameLen(frameLen), .cntFrames(cntFrames),
    .cntOverrun(cntOverrun), .cntCrcErr(cntCrcErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, sample write port, pass the rising edge
  task automatic drive(input bit v, input logic [7:0] b, input bit eof,
                       input bit crc, input bit ovr, input bit abt);
    @(negedge clk);
    inValid = v; inByte = b; inEof = eof; inCrcErr = crc;
    inOverrun = ovr; inAbort = abt;
    #1;
    smpWrEn = bufWrEn; smpAddr = bufWrAddr; smpData = bufWrData;
    @(posedge clk);
  endtask

  task automatic idle();
    drive(0, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic checkCounters(input string req);
    chk(cntFrames == 16'(expFrames), {req, " frames"}, cntFrames, expFrames);
    chk(cntOverrun == 16'(expOvr), {req, " overrun"}, cntOverrun, expOvr);
    chk(cntCrcErr == 16'(expCrc), {req, " crc"}, cntCrcErr, expCrc);
  endtask

  // stores n bytes from address start, checking each write
  task automatic sendBytes(input int n, input int start, input string req);
    for (int i = 0; i < n; i++) begin
      drive(1, 8'(i * 7 + 3), 0, 0, 0, 0);
      chk(smpWrEn && smpAddr == AW'(start + i) && smpData == 8'(i * 7 + 3),
          req, int'(smpAddr), start + i);
    end
  endtask

  task automatic t_reset();
    idle();
    chk(smpWrEn == 1'b0, "R1 wrEn", smpWrEn, 0);
    chk(frameOk == 1'b0, "R1 frameOk", frameOk, 0);
    checkCounters("R1");
  endtask

  task automatic t_keep();
    sendBytes(12, 0, "R2 write");
    drive(0, 0, 1, 0, 0, 0);
    idle();
    expFrames++;
    chk(frameOk == 1'b1, "R5 pulse", frameOk, 1);
    chk(frameLen == CW'(10), "R5 len", frameLen, 10);
    idle();
    chk(frameOk == 1'b0, "R5 single pulse", frameOk, 0);
    checkCounters("R5");
  endtask

  task automatic t_lastWithEof();
    sendBytes(10, 0, "R8 restart");
    drive(1, 8'hA5, 1, 0, 0, 0);
    chk(smpWrEn && smpAddr == AW'(10), "R10 last write", int'(smpAddr), 10);
    idle();
    expFrames++;
    chk(frameOk && frameLen == CW'(9), "R10 len", frameLen, 9);
    checkCounters("R10");
  endtask

  task automatic t_short();
    sendBytes(1, 0, "R8 addr0");
    drive(0, 0, 1, 0, 0, 0);
    idle();
    chk(!frameOk, "R6 short", frameOk, 0);
    sendBytes(9, 0, "R6 bytes");
    drive(0, 0, 1, 1, 0, 0);
    idle();
    chk(!frameOk, "R6 short crc", frameOk, 0);
    checkCounters("R6");
  endtask

  task automatic t_crc();
    sendBytes(12, 0, "R7 bytes");
    drive(0, 0, 1, 1, 0, 0);
    idle();
    expCrc++;
    chk(!frameOk, "R7 no pulse", frameOk, 0);
    checkCounters("R7");
  endtask

  task automatic t_zeroEof();
    drive(0, 0, 1, 0, 0, 0);
    idle();
    chk(!frameOk, "R12 empty", frameOk, 0);
    checkCounters("R12 empty");
  endtask

  task automatic t_overrun();
    sendBytes(3, 0, "R3 pre");
    drive(1, 8'h11, 0, 0, 1, 0);
    chk(!smpWrEn, "R3 ovr byte", smpWrEn, 0);
    expOvr++;
    drive(1, 8'h22, 0, 0, 0, 0);
    chk(!smpWrEn, "R3 drained", smpWrEn, 0);
    sendBytes(1, 0, "R3 resume");
    drive(0, 0, 1, 0, 0, 0);
    idle();
    checkCounters("R3");
    // overrun together with end of frame after a full-length frame
    sendBytes(12, 0, "R12 bytes");
    drive(1, 8'h33, 1, 0, 1, 0);
    idle();
    expOvr++;
    chk(!frameOk, "R12 ovr+eof", frameOk, 0);
    checkCounters("R12 ovr+eof");
  endtask

  task automatic t_big();
    sendBytes(BSZ, 0, "R4 fill");
    drive(1, 8'h44, 0, 0, 0, 0);
    chk(!smpWrEn, "R4 overflow byte", smpWrEn, 0);
    drive(1, 8'h55, 0, 0, 0, 0);
    chk(!smpWrEn, "R4 drained", smpWrEn, 0);
    sendBytes(12, 0, "R4 resume");
    drive(0, 0, 1, 0, 0, 0);
    idle();
    expFrames++;
    chk(frameOk && frameLen == CW'(10), "R4 later frame", frameLen, 10);
    checkCounters("R4");
  endtask

  task automatic t_abort();
    sendBytes(4, 0, "R9 pre");
    drive(1, 8'h66, 0, 0, 0, 1);
    chk(!smpWrEn, "R9 abort byte", smpWrEn, 0);
    sendBytes(1, 0, "R9 rewind");
    drive(1, 8'h77, 0, 0, 1, 0);
    expOvr++;
    drive(0, 0, 0, 0, 0, 1);
    drive(1, 8'h88, 0, 0, 0, 0);
    chk(!smpWrEn, "R9 abort while draining", smpWrEn, 0);
    sendBytes(1, 0, "R9 after drain");
    drive(0, 0, 1, 0, 0, 0);
    idle();
    checkCounters("R9");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 65540; i++) drive(1, 8'h00, 0, 0, 1, 0);
    idle();
    chk(cntOverrun == 16'hFFFF, "R11 saturate", cntOverrun, 65535);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    t_reset();
    t_keep();
    t_lastWithEof();
    t_short();
    t_crc();
    t_zeroEof();
    t_overrun();
    t_big();
    t_abort();
    t_saturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule